// File: doc/BRIEF.md
# Per-Port Secondary Bus Reset Sequencer

This block sequences the reset of the downstream ports of a switch, one independent channel per port. When software sets the reset-request bit in a port's bridge control register, that port's channel looks at the link once. If the link is up, it asks the link layer for hot-reset training sets. If the link is administratively disabled, it pulses a request that forces the link back to detection. If the link is simply down, it takes no link action. It then asks the queue to drop every packet that arrived from that port and is still waiting. On the first flush cycle it pulses a clear strobe for the port's non-sticky register fields.

Once the flush completes, the channel holds the port in reset for as long as software leaves the bit set. The hot-reset request stays on throughout that hold when the link was up. While the port is in reset, each incoming request is classified in the cycle after it arrives. A type 0 configuration access to the port's own bridge function is accepted. Any request aimed at the secondary side is rejected as an unsupported request. Out of reset, every request is accepted. Channels share no state, so a reset of one port leaves the others untouched.

Top module: `sbr_sequencer`

## Requirements
- R1: After reset, every output of every port is low and the port is not in reset.
- R2: With the port idle, a one on its control bit raises `in_reset_o` for that port on the next clock edge, and it stays high until the sequence returns to idle.
- R3: If the link is up when the sequence starts, `hot_reset_o` is high for every cycle of the hold phase and low in all other phases. It never rises when the link was not up.
- R4: If the link is disabled when the sequence starts, `force_detect_o` is high for exactly one cycle (the link-action cycle), and `hot_reset_o` stays low. A disabled indication wins over link-up.
- R5: `flush_req_o` rises one cycle after `in_reset_o` and stays high until the cycle after `flush_done_i` is seen. `nonsticky_clr_o` is high only during the first flush cycle.
- R6: After the flush, the port remains in the hold phase while its control bit stays one. It leaves reset on the first edge at which the bit is zero.
- R7: If the control bit is already zero when the flush completes, the port goes straight to idle, with no hold phase and no hot-reset request.
- R8: While the port is in reset, a request of kind 2'b01 (type 0 configuration to the bridge itself) gets `req_accept_o` one cycle later. Kinds 2'b00 (memory/IO to the secondary side), 2'b10 (type 1 configuration) and 2'b11 (message to the secondary side) get `req_ur_o` one cycle later instead.
- R9: While the port is not in reset, every valid request gets `req_accept_o`, never `req_ur_o`, one cycle later. With no valid request, both are low.
- R10: A reset sequence on one port changes no output of any other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_sbr_i | input | NUM_PORTS | Per-port secondary-bus-reset control bit, as written by software |
| link_up_i | input | NUM_PORTS | Per-port link-up indication |
| link_disabled_i | input | NUM_PORTS | Per-port link disabled indication |
| flush_done_i | input | NUM_PORTS | Per-port queue flush completion |
| req_valid_i | input | NUM_PORTS | Per-port request valid |
| req_kind_i | input | 2*NUM_PORTS | Per-port request kind, 2 bits each, port p in bits [2p+1:2p] |
| in_reset_o | output | NUM_PORTS | Port is held in secondary reset |
| hot_reset_o | output | NUM_PORTS | Request to send hot-reset training sets |
| force_detect_o | output | NUM_PORTS | One-cycle request to force the link to detection |
| flush_req_o | output | NUM_PORTS | Request to discard the port's queued packets |
| nonsticky_clr_o | output | NUM_PORTS | One-cycle clear of non-sticky register fields |
| req_accept_o | output | NUM_PORTS | Request accepted (registered) |
| req_ur_o | output | NUM_PORTS | Request answered as unsupported (registered) |

## Verification
A channel stuck in the wrong phase shows up at the ports within one clock. The bench follows the link-action, flush and hold phases by their outputs, cycle by cycle. A wrong latched link mode shows as a wrong one of `hot_reset_o` and `force_detect_o`. A missed or doubled clear shows as a clear strobe with the wrong length. A filter that reads the reset state wrongly flips accept and unsupported on the very next response. The bench sends all four request kinds in reset and out of it, and it watches an idle neighbour port the whole time.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LINK  = 2'd1,
        ST_FLUSH = 2'd2,
        ST_HOLD  = 2'd3
    } sbr_state_e;

    typedef enum logic [1:0] {
        MD_NONE   = 2'd0,
        MD_HOT    = 2'd1,
        MD_DETECT = 2'd2
    } link_mode_e;

    localparam logic [1:0] KIND_SEC_MEM = 2'b00;
    localparam logic [1:0] KIND_CFG0    = 2'b01;
    localparam logic [1:0] KIND_CFG1    = 2'b10;
    localparam logic [1:0] KIND_SEC_MSG = 2'b11;

    typedef struct packed {
        sbr_state_e state;
        link_mode_e mode;
        logic       nsclr;
    } fsm_regs_t;

    typedef struct packed {
        logic accept;
        logic ur;
    } filt_regs_t;

endpackage

// File: rtl/sbr_fsm.sv
module sbr_fsm
    import sbr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_sbr_i,
    input  logic link_up_i,
    input  logic link_disabled_i,
    input  logic flush_done_i,
    output logic in_reset_o,
    output logic hot_reset_o,
    output logic force_detect_o,
    output logic flush_req_o,
    output logic nonsticky_clr_o
);

    fsm_regs_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        r_d.nsclr = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (ctl_sbr_i) begin
                    r_d.state = ST_LINK;
                    if (link_disabled_i)  r_d.mode = MD_DETECT;
                    else if (link_up_i)   r_d.mode = MD_HOT;
                    else                  r_d.mode = MD_NONE;
                end
            end
            ST_LINK: begin
                r_d.state = ST_FLUSH;
                r_d.nsclr = 1'b1;
            end
            ST_FLUSH: begin
                if (flush_done_i) begin
                    if (ctl_sbr_i) r_d.state = ST_HOLD;
                    else begin
                        r_d.state = ST_IDLE;
                        r_d.mode  = MD_NONE;
                    end
                end
            end
            ST_HOLD: begin
                if (!ctl_sbr_i) begin
                    r_d.state = ST_IDLE;
                    r_d.mode  = MD_NONE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.mode  <= MD_NONE;
            r_q.nsclr <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_reset_o      = (r_q.state != ST_IDLE);
    assign hot_reset_o     = (r_q.state == ST_HOLD) && (r_q.mode == MD_HOT);
    assign force_detect_o  = (r_q.state == ST_LINK) && (r_q.mode == MD_DETECT);
    assign flush_req_o     = (r_q.state == ST_FLUSH);
    assign nonsticky_clr_o = r_q.nsclr;

    // R5: clear strobe lasts a single cycle
    p_nsclr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        nonsticky_clr_o |=> !nonsticky_clr_o);

    // R5: flush held until completion
    p_flush_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req_o && !flush_done_i) |=> flush_req_o);

    // R4: never both link actions
    p_link_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(hot_reset_o && force_detect_o));

    // R6: hold persists while the bit is set
    p_hold_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HOLD && ctl_sbr_i) |=> (r_q.state == ST_HOLD));

    // R7: early clear returns directly to idle
    p_early_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req_o && flush_done_i && !ctl_sbr_i) |=> !in_reset_o);

endmodule

// File: rtl/sbr_req_filter.sv
module sbr_req_filter
    import sbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_reset_i,
    input  logic       req_valid_i,
    input  logic [1:0] req_kind_i,
    output logic       req_accept_o,
    output logic       req_ur_o
);

    filt_regs_t f_q, f_d;
    logic       own_cfg;

    always_comb begin
        own_cfg   = (req_kind_i == KIND_CFG0);
        f_d.accept = req_valid_i && (!in_reset_i || own_cfg);
        f_d.ur     = req_valid_i && in_reset_i && !own_cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.accept <= 1'b0;
            f_q.ur     <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign req_accept_o = f_q.accept;
    assign req_ur_o     = f_q.ur;

    // R8: a response is never both accepted and unsupported
    p_resp_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_accept_o && req_ur_o));

    // R9: every valid request gets a response next cycle
    p_resp_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> (req_accept_o || req_ur_o));

    // R9: no response without a request
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !(req_accept_o || req_ur_o));

endmodule

// File: rtl/sbr_port_slice.sv
module sbr_port_slice
    import sbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_sbr_i,
    input  logic       link_up_i,
    input  logic       link_disabled_i,
    input  logic       flush_done_i,
    input  logic       req_valid_i,
    input  logic [1:0] req_kind_i,
    output logic       in_reset_o,
    output logic       hot_reset_o,
    output logic       force_detect_o,
    output logic       flush_req_o,
    output logic       nonsticky_clr_o,
    output logic       req_accept_o,
    output logic       req_ur_o
);

    logic in_reset_w;

    sbr_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .ctl_sbr_i       (ctl_sbr_i),
        .link_up_i       (link_up_i),
        .link_disabled_i (link_disabled_i),
        .flush_done_i    (flush_done_i),
        .in_reset_o      (in_reset_w),
        .hot_reset_o     (hot_reset_o),
        .force_detect_o  (force_detect_o),
        .flush_req_o     (flush_req_o),
        .nonsticky_clr_o (nonsticky_clr_o)
    );

    sbr_req_filter u_filt (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_reset_i   (in_reset_w),
        .req_valid_i  (req_valid_i),
        .req_kind_i   (req_kind_i),
        .req_accept_o (req_accept_o),
        .req_ur_o     (req_ur_o)
    );

    assign in_reset_o = in_reset_w;

    // R2: hot reset only while in reset
    p_hot_in_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hot_reset_o |-> in_reset_o);

endmodule

// File: rtl/sbr_sequencer.sv
module sbr_sequencer #(
    parameter int NUM_PORTS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PORTS-1:0]   ctl_sbr_i,
    input  logic [NUM_PORTS-1:0]   link_up_i,
    input  logic [NUM_PORTS-1:0]   link_disabled_i,
    input  logic [NUM_PORTS-1:0]   flush_done_i,
    input  logic [NUM_PORTS-1:0]   req_valid_i,
    input  logic [2*NUM_PORTS-1:0] req_kind_i,
    output logic [NUM_PORTS-1:0]   in_reset_o,
    output logic [NUM_PORTS-1:0]   hot_reset_o,
    output logic [NUM_PORTS-1:0]   force_detect_o,
    output logic [NUM_PORTS-1:0]   flush_req_o,
    output logic [NUM_PORTS-1:0]   nonsticky_clr_o,
    output logic [NUM_PORTS-1:0]   req_accept_o,
    output logic [NUM_PORTS-1:0]   req_ur_o
);

    localparam int KIND_W = 2;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        sbr_port_slice u_slice (
            .clk             (clk),
            .rst_n           (rst_n),
            .ctl_sbr_i       (ctl_sbr_i[p]),
            .link_up_i       (link_up_i[p]),
            .link_disabled_i (link_disabled_i[p]),
            .flush_done_i    (flush_done_i[p]),
            .req_valid_i     (req_valid_i[p]),
            .req_kind_i      (req_kind_i[p*KIND_W +: KIND_W]),
            .in_reset_o      (in_reset_o[p]),
            .hot_reset_o     (hot_reset_o[p]),
            .force_detect_o  (force_detect_o[p]),
            .flush_req_o     (flush_req_o[p]),
            .nonsticky_clr_o (nonsticky_clr_o[p]),
            .req_accept_o    (req_accept_o[p]),
            .req_ur_o        (req_ur_o[p])
        );

        // R10: a port without a request bit never enters reset on its own
        p_isolated_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctl_sbr_i[p] && !in_reset_o[p]) |=> !in_reset_o[p]);
    end

endmodule

// File: tb/sbr_sequencer_bench.sv
`timescale 1ns/1ps
module sbr_sequencer_bench;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] sbr = '0, lup = '0, ldis = '0, fdone = '0, rv = '0;
    logic [2*NP-1:0] rk = '0;
    logic [NP-1:0] inr, hot, fdet, freq, nsc, acc, ur;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sbr_sequencer #(.NUM_PORTS(NP)) u_sbr_sequencer (
        .clk(clk), .rst_n(rst_n), .ctl_sbr_i(sbr), .link_up_i(lup),
        .link_disabled_i(ldis), .flush_done_i(fdone), .req_valid_i(rv),
        .req_kind_i(rk), .in_reset_o(inr), .hot_reset_o(hot),
        .force_detect_o(fdet), .flush_req_o(freq), .nonsticky_clr_o(nsc),
        .req_accept_o(acc), .req_ur_o(ur)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // port 0 outputs packed: {inr,hot,fdet,freq,nsc}
    function automatic logic [4:0] p0();
        return {inr[0], hot[0], fdet[0], freq[0], nsc[0]};
    endfunction

    task automatic t_reset();
        chk("R1 reset outputs", {inr, hot, fdet, freq, nsc, acc, ur}, '0);
    endtask

    task automatic t_hot_path();
        sbr[0] = 1; lup[0] = 1;
        step();
        chk("R2 enter link action", p0(), 5'b10000);
        chk("R10 neighbours idle", {inr[NP-1:1], hot[NP-1:1]}, '0);
        step();
        chk("R5 flush entry with clear", p0(), 5'b10011);
        step();
        chk("R5 flush held, clear gone", p0(), 5'b10010);
        fdone[0] = 1;
        step();
        fdone[0] = 0;
        chk("R3 hold with hot reset", p0(), 5'b11000);
        for (int i = 0; i < 5; i++) step();
        chk("R6 still held while bit set", p0(), 5'b11000);
        chk("R10 neighbours still idle", {inr[NP-1:1], freq[NP-1:1], nsc[NP-1:1]}, '0);
        sbr[0] = 0;
        step();
        chk("R6 R3 released after clear", p0(), 5'b00000);
        lup[0] = 0;
    endtask

    task automatic t_detect_path();
        sbr[0] = 1; ldis[0] = 1; lup[0] = 1;
        step();
        chk("R4 force detect pulse", p0(), 5'b10100);
        step();
        chk("R4 pulse ends", p0(), 5'b10011);
        fdone[0] = 1;
        step();
        fdone[0] = 0;
        chk("R4 hold without hot reset", p0(), 5'b10000);
        sbr[0] = 0;
        step();
        chk("R6 back to idle", p0(), 5'b00000);
        ldis[0] = 0; lup[0] = 0;
    endtask

    task automatic t_early_clear();
        sbr[0] = 1; lup[0] = 1;
        step();
        step();
        sbr[0] = 0;
        step();
        chk("R7 flush still running after clear", p0(), 5'b10010);
        fdone[0] = 1;
        step();
        fdone[0] = 0;
        chk("R7 idle without hold", p0(), 5'b00000);
        step();
        chk("R7 no hot reset afterwards", p0(), 5'b00000);
        lup[0] = 0;
    endtask

    task automatic send(input logic [1:0] kind, input logic [1:0] exp, input string req);
        rv[1] = 1; rk[3:2] = kind;
        step();
        rv[1] = 0;
        chk(req, {acc[1], ur[1]}, exp);
    endtask

    task automatic t_filter();
        send(2'b00, 2'b10, "R9 mem accepted idle");
        send(2'b01, 2'b10, "R9 cfg0 accepted idle");
        send(2'b11, 2'b10, "R9 msg accepted idle");
        step();
        chk("R9 no request no response", {acc[1], ur[1]}, 2'b00);
        sbr[1] = 1;
        step();
        send(2'b01, 2'b10, "R8 cfg0 accepted in reset");
        send(2'b00, 2'b01, "R8 mem unsupported in reset");
        send(2'b10, 2'b01, "R8 cfg1 unsupported in reset");
        send(2'b11, 2'b01, "R8 msg unsupported in reset");
        chk("R10 port0 untouched", p0(), 5'b00000);
        fdone[1] = 1;
        step();
        fdone[1] = 0;
        sbr[1] = 0;
        step();
        chk("R2 port1 idle again", inr[1], 1'b0);
        send(2'b00, 2'b10, "R9 mem accepted after reset");
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1;
        step();
        t_reset();
        t_hot_path();
        t_detect_path();
        t_early_clear();
        t_filter();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule